// File: doc/BRIEF.md
# Indirect Internal Memory Access Bridge

This block sits between a simple host register bus and three internal targets: a single-port synchronous SRAM with 32-bit words, a peripheral register port that takes byte-lane enables, and a shared-register port. The host sees ten directly mapped 32-bit registers. Host accesses take a few clocks to finish. The host raises `host_req` and holds it with its index, direction and write data until `host_ready` pulses for one cycle. On a read, `host_rdata` is valid in that same cycle.

SRAM traffic runs through two independent byte-address pointers. The host loads a pointer once. It then streams words through the memory write-data or read-data register, and the matching pointer advances by one dword after each access. Peripheral traffic uses a write address register and a read address register. Each holds a 16-bit offset and a byte count field. Shared-register traffic uses a control word that carries an offset and an opcode. Writing the control word starts the internal read or write, and a data register holds the value going out or coming back.

The controller is a single state machine:
- **IDLE** accepts a request. Every request moves to one of three places:
  - **DONE**, for register accesses and ignored accesses.
  - **MEM_WR**, **PRPH_WR** or **SHR_WR**, for data writes and the shared write opcode.
  - **MEM_RD**, **PRPH_RD** or **SHR_RD**, for data reads and the shared read opcode.
- Each write state moves straight to DONE.
- Each read state moves to its capture state (**MEM_CAP**, **PRPH_CAP** or **SHR_CAP**), which then moves to DONE.
- DONE raises `host_ready` and returns to IDLE.

Top module: `ind_mem_bridge`

## Requirements
- R1: After reset, `host_ready` and all internal enables are low, and every host-visible register reads 0.
- R2: A host write to index 2 (memory write data) writes the word to SRAM word `wptr[9:2]`. The memory write pointer (index 1) then reads back 4 higher.
- R3: A host read of index 3 (memory read data) returns the SRAM word at `rptr[9:2]`. The memory read pointer (index 0) then reads back 4 higher.
- R4: The read pointer and the write pointer are independent. Streaming through one never moves the other.
- R5: `host_ready` is a one-cycle pulse. It comes a fixed number of cycles after the request is accepted:
  - 1 cycle for register accesses and for control words with opcode 0 or 1.
  - 2 cycles for memory or peripheral data writes and for shared opcode 3.
  - 3 cycles for memory or peripheral data reads and for shared opcode 2.
- R6: A host write to index 6 (peripheral write data) performs one peripheral write at offset bits 15:0 of index 4 (peripheral write address). Lane enables come from bits 25:24 of that register (n gives lanes 0..n, so 3 is a full dword). Bytes above the count are driven as zero.
- R7: A host read of index 7 (peripheral read data) reads at offset bits 15:0 of index 5 (peripheral read address). It returns only the bytes up to the count in bits 25:24, zero-extended.
- R8: A write to index 8 (shared control) with bits 29:28 = 3 performs one shared write at offset bits 15:0, using the value held in index 9 (shared data).
- R9: A write to index 8 with bits 29:28 = 2 performs one shared read at offset bits 15:0. The result is placed in index 9.
- R10: Control opcodes 0 and 1 cause no shared access and leave index 9 unchanged.
- R11: At most one internal port is enabled in any cycle, and each enable lasts one cycle.
- R12: Writes to the read-only indices 3 and 7 and to unmapped indices (10 to 15) change nothing. Reads of unmapped indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host request, held until host_ready |
| host_write | input | 1 | 1 = write, 0 = read |
| host_idx | input | 4 | Host register index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid with host_ready |
| host_ready | output | 1 | One-cycle completion pulse |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | SRAM_AW | SRAM word index |
| sram_wdata | output | 32 | SRAM write data |
| sram_rdata | input | 32 | SRAM read data, one cycle after enable |
| prph_en | output | 1 | Peripheral access enable |
| prph_we | output | 1 | Peripheral write enable |
| prph_addr | output | 16 | Peripheral register offset |
| prph_be | output | 4 | Peripheral byte-lane enables |
| prph_wdata | output | 32 | Peripheral write data, unused lanes zero |
| prph_rdata | input | 32 | Peripheral read data, one cycle after enable |
| shr_en | output | 1 | Shared-register access enable |
| shr_we | output | 1 | Shared-register write enable |
| shr_addr | output | 16 | Shared-register offset |
| shr_wdata | output | 32 | Shared-register write data |
| shr_rdata | input | 32 | Shared-register read data, one cycle after enable |

## Verification
The bench targets the following corner cases:
- **Pointer coupling.** It interleaves write streams and read streams to catch pointers that are shared or that advance on the wrong access. Such a design would return stale words or read back the wrong pointer value.
- **Short peripheral counts.** It writes over non-zero existing contents with counts 0 and 1, and reads with counts 0 and 2. A design that ignored the lane enables would clobber the upper bytes or leak them into the read result.
- **No-op opcodes.** It issues shared control words with opcodes 0 and 1 after a real read. A faulty decode would fire a port access or overwrite the held data.
- **Latency.** It checks the completion latency of every request kind. A design that captured SRAM data one cycle early would return the previous word.

// File: rtl/imb_pkg.sv
`timescale 1ns/1ps
package imb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MEM_WR,
        ST_MEM_RD,
        ST_MEM_CAP,
        ST_PRPH_WR,
        ST_PRPH_RD,
        ST_PRPH_CAP,
        ST_SHR_WR,
        ST_SHR_RD,
        ST_SHR_CAP,
        ST_DONE
    } imb_state_e;

    // host register indices
    localparam logic [3:0] IX_MRPTR  = 4'd0;
    localparam logic [3:0] IX_MWPTR  = 4'd1;
    localparam logic [3:0] IX_MWDAT  = 4'd2;
    localparam logic [3:0] IX_MRDAT  = 4'd3;
    localparam logic [3:0] IX_PWADDR = 4'd4;
    localparam logic [3:0] IX_PRADDR = 4'd5;
    localparam logic [3:0] IX_PWDAT  = 4'd6;
    localparam logic [3:0] IX_PRDAT  = 4'd7;
    localparam logic [3:0] IX_SCTRL  = 4'd8;
    localparam logic [3:0] IX_SDAT   = 4'd9;

    // field positions that the internal ports decode
    localparam int OFF_W      = 16;
    localparam int CNT_LSB    = 24;
    localparam int OP_LSB     = 28;

    localparam logic [1:0] OP_SHR_RD = 2'd2;
    localparam logic [1:0] OP_SHR_WR = 2'd3;

    typedef struct packed {
        logic acc;
        logic mem_wr;
        logic mem_rd;
        logic mem_cap;
        logic prph_wr;
        logic prph_rd;
        logic prph_cap;
        logic shr_wr;
        logic shr_rd;
        logic shr_cap;
        logic ready;
    } imb_strobe_t;

endpackage

// File: rtl/imb_ctrl_fsm.sv
`timescale 1ns/1ps
module imb_ctrl_fsm
    import imb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_write,
    input  logic [3:0]  host_idx,
    input  logic [1:0]  shr_op,
    output imb_strobe_t stb
);

    imb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    if (host_write) begin
                        if (host_idx == IX_MWDAT)       state_d = ST_MEM_WR;
                        else if (host_idx == IX_PWDAT)  state_d = ST_PRPH_WR;
                        else if (host_idx == IX_SCTRL && shr_op == OP_SHR_WR) state_d = ST_SHR_WR;
                        else if (host_idx == IX_SCTRL && shr_op == OP_SHR_RD) state_d = ST_SHR_RD;
                        else                            state_d = ST_DONE;
                    end else begin
                        if (host_idx == IX_MRDAT)       state_d = ST_MEM_RD;
                        else if (host_idx == IX_PRDAT)  state_d = ST_PRPH_RD;
                        else                            state_d = ST_DONE;
                    end
                end
            end
            ST_MEM_WR:   state_d = ST_DONE;
            ST_MEM_RD:   state_d = ST_MEM_CAP;
            ST_MEM_CAP:  state_d = ST_DONE;
            ST_PRPH_WR:  state_d = ST_DONE;
            ST_PRPH_RD:  state_d = ST_PRPH_CAP;
            ST_PRPH_CAP: state_d = ST_DONE;
            ST_SHR_WR:   state_d = ST_DONE;
            ST_SHR_RD:   state_d = ST_SHR_CAP;
            ST_SHR_CAP:  state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        stb = '0;
        unique case (state_q)
            ST_IDLE:     stb.acc      = host_req;
            ST_MEM_WR:   stb.mem_wr   = 1'b1;
            ST_MEM_RD:   stb.mem_rd   = 1'b1;
            ST_MEM_CAP:  stb.mem_cap  = 1'b1;
            ST_PRPH_WR:  stb.prph_wr  = 1'b1;
            ST_PRPH_RD:  stb.prph_rd  = 1'b1;
            ST_PRPH_CAP: stb.prph_cap = 1'b1;
            ST_SHR_WR:   stb.shr_wr   = 1'b1;
            ST_SHR_RD:   stb.shr_rd   = 1'b1;
            ST_SHR_CAP:  stb.shr_cap  = 1'b1;
            ST_DONE:     stb.ready    = 1'b1;
            default:     stb = '0;
        endcase
    end

endmodule

// File: rtl/imb_lane_mask.sv
`timescale 1ns/1ps
module imb_lane_mask #(
    parameter  int DATA_W = 32,
    localparam int NB     = DATA_W / 8,
    localparam int CNT_W  = $clog2(NB)
) (
    input  logic [CNT_W-1:0]  count,
    input  logic [DATA_W-1:0] data_in,
    output logic [NB-1:0]     lane_en,
    output logic [DATA_W-1:0] data_out
);

    // count n enables lanes 0..n; lanes above are forced to zero
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lane_en[g]         = (int'(count) >= g);
        assign data_out[8*g +: 8] = lane_en[g] ? data_in[8*g +: 8] : 8'h00;
    end

endmodule

// File: rtl/imb_reg_bank.sv
`timescale 1ns/1ps
module imb_reg_bank
    import imb_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int PTR_W  = 32,
    localparam int NB     = DATA_W / 8,
    localparam int CNT_W  = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  imb_strobe_t       stb,
    input  logic              host_write,
    input  logic [3:0]        host_idx,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] sram_rdata,
    input  logic [DATA_W-1:0] prph_rd_masked,
    input  logic [DATA_W-1:0] shr_rdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [PTR_W-1:0]  mem_rptr,
    output logic [PTR_W-1:0]  mem_wptr,
    output logic [DATA_W-1:0] mem_wdat,
    output logic [OFF_W-1:0]  prph_woff,
    output logic [CNT_W-1:0]  prph_wcnt,
    output logic [OFF_W-1:0]  prph_roff,
    output logic [CNT_W-1:0]  prph_rcnt,
    output logic [DATA_W-1:0] prph_wdat,
    output logic [OFF_W-1:0]  shr_off,
    output logic [DATA_W-1:0] shr_dat
);

    localparam logic [PTR_W-1:0] STEP = PTR_W'(NB);

    logic [DATA_W-1:0] pwaddr_q, praddr_q, sctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
            mem_rptr   <= '0;
            mem_wptr   <= '0;
            mem_wdat   <= '0;
            pwaddr_q   <= '0;
            praddr_q   <= '0;
            prph_wdat  <= '0;
            sctrl_q    <= '0;
            shr_dat    <= '0;
        end else begin
            if (stb.acc) begin
                if (host_write) begin
                    case (host_idx)
                        IX_MRPTR:  mem_rptr  <= PTR_W'(host_wdata);
                        IX_MWPTR:  mem_wptr  <= PTR_W'(host_wdata);
                        IX_MWDAT:  mem_wdat  <= host_wdata;
                        IX_PWADDR: pwaddr_q  <= host_wdata;
                        IX_PRADDR: praddr_q  <= host_wdata;
                        IX_PWDAT:  prph_wdat <= host_wdata;
                        IX_SCTRL:  sctrl_q   <= host_wdata;
                        IX_SDAT:   shr_dat   <= host_wdata;
                        default: ;
                    endcase
                end else begin
                    case (host_idx)
                        IX_MRPTR:  host_rdata <= DATA_W'(mem_rptr);
                        IX_MWPTR:  host_rdata <= DATA_W'(mem_wptr);
                        IX_PWADDR: host_rdata <= pwaddr_q;
                        IX_PRADDR: host_rdata <= praddr_q;
                        IX_SCTRL:  host_rdata <= sctrl_q;
                        IX_SDAT:   host_rdata <= shr_dat;
                        default:   host_rdata <= '0;
                    endcase
                end
            end
            if (stb.mem_wr) mem_wptr <= mem_wptr + STEP;
            if (stb.mem_cap) begin
                host_rdata <= sram_rdata;
                mem_rptr   <= mem_rptr + STEP;
            end
            if (stb.prph_cap) host_rdata <= prph_rd_masked;
            if (stb.shr_cap)  shr_dat    <= shr_rdata;
        end
    end

    assign prph_woff = pwaddr_q[OFF_W-1:0];
    assign prph_wcnt = pwaddr_q[CNT_LSB +: CNT_W];
    assign prph_roff = praddr_q[OFF_W-1:0];
    assign prph_rcnt = praddr_q[CNT_LSB +: CNT_W];
    assign shr_off   = sctrl_q[OFF_W-1:0];

endmodule

// File: rtl/ind_mem_bridge.sv
`timescale 1ns/1ps
module ind_mem_bridge
    import imb_pkg::*;
#(
    parameter  int SRAM_AW = 8,
    parameter  int DATA_W  = 32,
    parameter  int PTR_W   = 32,
    localparam int NB      = DATA_W / 8,
    localparam int CNT_W   = $clog2(NB),
    localparam int BYTE_SH = $clog2(NB)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_write,
    input  logic [3:0]         host_idx,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               host_ready,
    output logic               sram_en,
    output logic               sram_we,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [DATA_W-1:0]  sram_wdata,
    input  logic [DATA_W-1:0]  sram_rdata,
    output logic               prph_en,
    output logic               prph_we,
    output logic [OFF_W-1:0]   prph_addr,
    output logic [NB-1:0]      prph_be,
    output logic [DATA_W-1:0]  prph_wdata,
    input  logic [DATA_W-1:0]  prph_rdata,
    output logic               shr_en,
    output logic               shr_we,
    output logic [OFF_W-1:0]   shr_addr,
    output logic [DATA_W-1:0]  shr_wdata,
    input  logic [DATA_W-1:0]  shr_rdata
);

    imb_strobe_t       stb;
    logic [PTR_W-1:0]  mem_rptr, mem_wptr;
    logic [DATA_W-1:0] mem_wdat, prph_wdat, prph_rd_masked;
    logic [OFF_W-1:0]  prph_woff, prph_roff, shr_off;
    logic [CNT_W-1:0]  prph_wcnt, prph_rcnt;
    logic [NB-1:0]     be_wr, be_rd;

    imb_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_write (host_write),
        .host_idx   (host_idx),
        .shr_op     (host_wdata[OP_LSB +: 2]),
        .stb        (stb)
    );

    imb_reg_bank #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .stb            (stb),
        .host_write     (host_write),
        .host_idx       (host_idx),
        .host_wdata     (host_wdata),
        .sram_rdata     (sram_rdata),
        .prph_rd_masked (prph_rd_masked),
        .shr_rdata      (shr_rdata),
        .host_rdata     (host_rdata),
        .mem_rptr       (mem_rptr),
        .mem_wptr       (mem_wptr),
        .mem_wdat       (mem_wdat),
        .prph_woff      (prph_woff),
        .prph_wcnt      (prph_wcnt),
        .prph_roff      (prph_roff),
        .prph_rcnt      (prph_rcnt),
        .prph_wdat      (prph_wdat),
        .shr_off        (shr_off),
        .shr_dat        (shr_wdata)
    );

    imb_lane_mask #(.DATA_W(DATA_W)) u_wr_mask (
        .count    (prph_wcnt),
        .data_in  (prph_wdat),
        .lane_en  (be_wr),
        .data_out (prph_wdata)
    );

    imb_lane_mask #(.DATA_W(DATA_W)) u_rd_mask (
        .count    (prph_rcnt),
        .data_in  (prph_rdata),
        .lane_en  (be_rd),
        .data_out (prph_rd_masked)
    );

    assign host_ready = stb.ready;

    assign sram_en    = stb.mem_wr | stb.mem_rd;
    assign sram_we    = stb.mem_wr;
    assign sram_addr  = stb.mem_wr ? mem_wptr[BYTE_SH +: SRAM_AW] : mem_rptr[BYTE_SH +: SRAM_AW];
    assign sram_wdata = mem_wdat;

    assign prph_en    = stb.prph_wr | stb.prph_rd;
    assign prph_we    = stb.prph_wr;
    assign prph_addr  = stb.prph_wr ? prph_woff : prph_roff;
    assign prph_be    = stb.prph_wr ? be_wr : be_rd;

    assign shr_en     = stb.shr_wr | stb.shr_rd;
    assign shr_we     = stb.shr_wr;
    assign shr_addr   = shr_off;

endmodule

// File: rtl/imb_checker.sv
`timescale 1ns/1ps
module imb_checker #(
    parameter int PTR_W = 32,
    parameter int NB    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_ready,
    input logic             sram_en,
    input logic             sram_we,
    input logic             prph_en,
    input logic [NB-1:0]    prph_be,
    input logic             shr_en,
    input logic [PTR_W-1:0] mem_wptr,
    input logic [PTR_W-1:0] mem_rptr
);

    localparam logic [PTR_W-1:0] STEP = PTR_W'(NB);

    assert_one_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sram_en, prph_en, shr_en}));

    assert_shr_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        shr_en |=> !shr_en);

    assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

    assert_wptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_en && sram_we) |=> (mem_wptr == $past(mem_wptr) + STEP));

    assert_rptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_en && sram_we) |=> $stable(mem_rptr));

    assert_rptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_en && !sram_we) |=> ##1 (mem_rptr == $past(mem_rptr, 2) + STEP));

    assert_lane_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prph_en |-> (prph_be[0] && $countones(prph_be + 1'b1) <= 1));

endmodule

bind ind_mem_bridge imb_checker #(.PTR_W(PTR_W), .NB(NB)) u_imb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ready (host_ready),
    .sram_en    (sram_en),
    .sram_we    (sram_we),
    .prph_en    (prph_en),
    .prph_be    (prph_be),
    .shr_en     (shr_en),
    .mem_wptr   (mem_wptr),
    .mem_rptr   (mem_rptr)
);

// File: tb/ind_mem_bridge_tb_top.sv
`timescale 1ns/1ps
module ind_mem_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_write = 1'b0;
    logic [3:0]  host_idx = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ready;
    logic        sram_en, sram_we;
    logic [7:0]  sram_addr;
    logic [31:0] sram_wdata;
    logic [31:0] sram_rdata = '0;
    logic        prph_en, prph_we;
    logic [15:0] prph_addr;
    logic [3:0]  prph_be;
    logic [31:0] prph_wdata;
    logic [31:0] prph_rdata = '0;
    logic        shr_en, shr_we;
    logic [15:0] shr_addr;
    logic [31:0] shr_wdata;
    logic [31:0] shr_rdata = '0;

    int vectors = 0;
    int miscompares = 0;
    int overlap = 0;
    int shr_hits = 0;
    int sram_wr_hits = 0;
    bit finished = 0;

    logic [31:0] sram_m [256];
    logic [31:0] prph_m [64];
    logic [31:0] shr_m  [64];

    always #2.5 clk = ~clk;

    ind_mem_bridge dut_i (.*);

    // environment models of the internal targets
    always @(posedge clk) begin
        if (sram_en) begin
            if (sram_we) begin sram_m[sram_addr] <= sram_wdata; sram_wr_hits <= sram_wr_hits + 1; end
            else sram_rdata <= sram_m[sram_addr];
        end
        if (prph_en) begin
            if (prph_we) begin
                for (int b = 0; b < 4; b++)
                    if (prph_be[b]) prph_m[prph_addr[7:2]][8*b +: 8] <= prph_wdata[8*b +: 8];
            end else prph_rdata <= prph_m[prph_addr[7:2]];
        end
        if (shr_en) begin
            shr_hits <= shr_hits + 1;
            if (shr_we) shr_m[shr_addr[7:2]] <= shr_wdata;
            else shr_rdata <= shr_m[shr_addr[7:2]];
        end
    end

    // every-clock comparison: at most one internal port active (R11)
    always @(negedge clk)
        if (rst_n && ((32'(sram_en) + 32'(prph_en) + 32'(shr_en)) > 1)) overlap++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_op(input logic wr, input logic [3:0] idx, input logic [31:0] wd,
                           output logic [31:0] rd, output int lat);
        @(negedge clk);
        host_req = 1'b1; host_write = wr; host_idx = idx; host_wdata = wd;
        lat = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            lat++;
            if (host_ready) break;
        end
        rd = host_rdata;
        host_req = 1'b0;
    endtask

    task automatic wr_reg(input string tag, input logic [3:0] idx, input logic [31:0] wd, input int exp_lat);
        logic [31:0] rd; int lat;
        host_op(1'b1, idx, wd, rd, lat);
        chk(tag, 32'(lat), 32'(exp_lat));
    endtask

    task automatic rd_reg(input string tag, input logic [3:0] idx, input logic [31:0] exp, input int exp_lat);
        logic [31:0] rd; int lat;
        host_op(1'b0, idx, 32'h0, rd, lat);
        chk(tag, rd, exp);
        chk({tag, " latency"}, 32'(lat), 32'(exp_lat));
    endtask

    initial begin
        int sh_before; int sw_before;
        for (int i = 0; i < 256; i++) sram_m[i] = 32'hC0DE0000 + 32'(i);
        for (int i = 0; i < 64; i++) begin prph_m[i] = 32'hAABBCCDD; shr_m[i] = 32'h5A5A0000 + 32'(i); end

        repeat (3) @(negedge clk);
        chk("R1 ready after reset", 32'(host_ready), 0);
        chk("R1 enables after reset", {29'd0, sram_en, prph_en, shr_en}, 0);
        rst_n = 1'b1;
        rd_reg("R1 read ptr", 4'd0, 32'h0, 1);
        rd_reg("R1 write ptr", 4'd1, 32'h0, 1);
        rd_reg("R1 shared ctrl", 4'd8, 32'h0, 1);
        rd_reg("R1 shared data", 4'd9, 32'h0, 1);

        // R2 / R5: write stream
        wr_reg("R5 ptr write latency", 4'd1, 32'h20, 1);
        for (int i = 0; i < 3; i++) wr_reg("R5 mem write latency R2", 4'd2, 32'h1000_0000 + 32'(i), 2);
        for (int i = 0; i < 3; i++) chk("R2 sram content", sram_m[8 + i], 32'h1000_0000 + 32'(i));
        rd_reg("R2 write ptr advanced", 4'd1, 32'h2C, 1);
        rd_reg("R4 read ptr untouched", 4'd0, 32'h0, 1);

        // R3: read stream
        wr_reg("R3 set read ptr", 4'd0, 32'h20, 1);
        for (int i = 0; i < 3; i++) rd_reg("R3 stream read", 4'd3, 32'h1000_0000 + 32'(i), 3);
        wr_reg("R3 set read ptr high", 4'd0, 32'h100, 1);
        rd_reg("R3 preload word 64", 4'd3, 32'hC0DE0040, 3);
        rd_reg("R3 preload word 65", 4'd3, 32'hC0DE0041, 3);
        rd_reg("R3 read ptr advanced", 4'd0, 32'h108, 1);
        rd_reg("R4 write ptr untouched", 4'd1, 32'h2C, 1);

        // R6: peripheral writes with counts 3, 1, 0
        wr_reg("R6 paddr", 4'd4, 32'h0300_0040, 1);
        wr_reg("R6 full write", 4'd6, 32'h11223344, 2);
        chk("R6 full dword", prph_m[16], 32'h11223344);
        wr_reg("R6 paddr c1", 4'd4, 32'h0100_0044, 1);
        wr_reg("R6 half write", 4'd6, 32'h55667788, 2);
        chk("R6 two lanes", prph_m[17], 32'hAABB7788);
        wr_reg("R6 paddr c0", 4'd4, 32'h0000_0048, 1);
        wr_reg("R6 byte write", 4'd6, 32'h12345699, 2);
        chk("R6 one lane", prph_m[18], 32'hAABBCC99);
        rd_reg("R6 paddr readback", 4'd4, 32'h0000_0048, 1);

        // R7: peripheral reads with counts 0, 2, 3
        wr_reg("R7 praddr c0", 4'd5, 32'h0000_0044, 1);
        rd_reg("R7 byte read", 4'd7, 32'h0000_0088, 3);
        wr_reg("R7 praddr c2", 4'd5, 32'h0200_0040, 1);
        rd_reg("R7 three byte read", 4'd7, 32'h0022_3344, 3);
        wr_reg("R7 praddr c3", 4'd5, 32'h0300_0044, 1);
        rd_reg("R7 dword read", 4'd7, 32'hAABB7788, 3);

        // R8: shared write
        sh_before = shr_hits;
        wr_reg("R8 load data", 4'd9, 32'hFEEDF00D, 1);
        wr_reg("R8 op3 latency", 4'd8, 32'h3000_01DC, 2);
        chk("R8 shared content", shr_m[55], 32'hFEEDF00D);
        chk("R8 one access", 32'(shr_hits - sh_before), 1);

        // R9: shared read
        shr_m[10] = 32'h0BADCAFE;
        wr_reg("R9 op2 latency", 4'd8, 32'h2000_0028, 3);
        rd_reg("R9 data loaded", 4'd9, 32'h0BADCAFE, 1);

        // R10: opcodes 0 and 1
        sh_before = shr_hits;
        wr_reg("R10 op1 latency", 4'd8, 32'h1000_01DC, 1);
        wr_reg("R10 op0 latency", 4'd8, 32'h0000_01DC, 1);
        chk("R10 no access", 32'(shr_hits - sh_before), 0);
        rd_reg("R10 data unchanged", 4'd9, 32'h0BADCAFE, 1);
        chk("R10 shared mem unchanged", shr_m[55], 32'hFEEDF00D);
        rd_reg("R10 ctrl readback", 4'd8, 32'h0000_01DC, 1);

        // R12: ignored writes
        sw_before = sram_wr_hits;
        wr_reg("R12 write to mem rdata", 4'd3, 32'hDEAD0001, 1);
        wr_reg("R12 write to prph rdata", 4'd7, 32'hDEAD0002, 1);
        wr_reg("R12 write unmapped", 4'd12, 32'hDEAD0003, 1);
        chk("R12 no sram write", 32'(sram_wr_hits - sw_before), 0);
        rd_reg("R12 read ptr kept", 4'd0, 32'h108, 1);
        rd_reg("R12 unmapped reads zero", 4'd12, 32'h0, 1);
        rd_reg("R12 praddr kept", 4'd5, 32'h0300_0044, 1);

        chk("R11 port exclusivity every clock", 32'(overlap), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule